// File: doc/BRIEF.md
# Dual-Mode 4:1 Parallel-to-Serial Converter

This block turns a stream of 4-bit parallel words into a serial bit stream, one bit on each cycle of a fast serial clock. A free-running counter on the serial clock divides it by four to form the parallel read clock, and it also picks which bit of the current word goes to the line. A new word is taken into the shift register each time the counter wraps. The word itself comes from a capture stage fed by the upstream elastic buffer.

The capture stage samples the parallel clock and data with the serial clock and detects the parallel clock's transitions. In full-rate mode only rising transitions capture a word. In half-rate mode the parallel clock runs at half frequency, so both transitions capture. A second bit of the mode setting gates a copy of the serial clock onto an output pin.

An auxiliary output serves system loopback. When its power control is low it is held at 0. Otherwise it carries either a copy of the serial data or the quarter-rate read clock, selected by an enable input.

Top module: `pser_tx`

## Requirements
- R1: Each word is transmitted most significant bit first. Bit 3 appears while the counter is at 0, bit 2 at 1, bit 1 at 2 and bit 0 at 3, one bit per serial clock cycle on `sdata_out`.
- R2: The shift register loads the most recently captured word on the clock edge where the counter wraps from 3 to 0. That word's bit 3 is on `sdata_out` during the cycle that follows.
- R3: With `mode_in[1]` = 0 (full rate), a word is captured only when the sampled parallel clock goes from 0 to 1. The value captured is `pdata_in` sampled on the same serial clock edge that first sees the high level. Falling transitions leave the captured word unchanged.
- R4: With `mode_in[1]` = 1 (half rate), both a 0-to-1 and a 1-to-0 transition of the sampled parallel clock capture `pdata_in` sampled on the edge that first sees the new level.
- R5: `rclk_out` is the serial clock divided by four. It is low while the counter is at 0 or 1 and high while it is at 2 or 3.
- R6: `sclk_out` follows `clk_ser` when `mode_in[0]` = 1 and is held at 0 when `mode_in[0]` = 0.
- R7: With `lb_pwr` = 0, `aux_out` is 0 whatever `lb_en` is.
- R8: With `lb_pwr` = 1 and `lb_en` = 1, `aux_out` equals `sdata_out`.
- R9: With `lb_pwr` = 1 and `lb_en` = 0, `aux_out` equals `rclk_out`.
- R10: While `rst_n` is low, the counter is 0 and both the shift register and the captured word are 0. As a result `sdata_out` and `rclk_out` are 0, and the first frame after reset sends four zero bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pclk_in | input | 1 | Parallel input clock, sampled by clk_ser |
| pdata_in | input | 4 | Parallel input word |
| mode_in | input | 2 | Bit 1: half-rate double-edge capture; bit 0: serial clock output enable |
| lb_en | input | 1 | Loopback select: 1 carries serial data, 0 carries the read clock |
| lb_pwr | input | 1 | Loopback output power control, 0 holds the output low |
| sdata_out | output | 1 | Serial data, MSB first |
| sclk_out | output | 1 | Gated copy of the serial clock |
| rclk_out | output | 1 | Parallel read clock, serial clock divided by four |
| aux_out | output | 1 | Loopback output |

## Verification
The assertions check four things on every cycle. The load on counter wrap puts the captured word's MSB on the line. The read clock rises at the mid-frame point. In full-rate mode the captured word stays unchanged across parallel clock falls, and in half-rate mode it takes in the input on every transition. The loopback output is held low or tracks the serial data as its controls require. Only the bench's scenarios can show the whole MSB-first bit order across many word patterns and the exact capture latency relative to the frame. They also show that a falling edge in full-rate mode would visibly replace a word, that the serial clock gating works, and that the reset frame is zero.

// File: rtl/pser_pkg.sv
package pser_pkg;

    typedef enum logic {
        CAP_SINGLE = 1'b0,
        CAP_DOUBLE = 1'b1
    } cap_mode_e;

endpackage

// File: rtl/pser_capture.sv
module pser_capture
    import pser_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_clk,
    input  logic [WORD_W-1:0] pin_data,
    input  cap_mode_e         cap_mode,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic              smp_now;
        logic              smp_old;
        logic [WORD_W-1:0] dat;
        logic [WORD_W-1:0] hold;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    edge_up, edge_down, take;

    always_comb begin
        st_d      = st_q;
        edge_up   = st_q.smp_now & ~st_q.smp_old;
        edge_down = ~st_q.smp_now & st_q.smp_old;
        take      = edge_up | (edge_down & (cap_mode == CAP_DOUBLE));
        st_d.smp_now = pin_clk;
        st_d.smp_old = st_q.smp_now;
        st_d.dat     = pin_data;
        if (take) begin
            st_d.hold = st_q.dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.hold;

    // R3: a falling parallel clock never replaces the word in full-rate mode
    p_single_edge_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == CAP_SINGLE && edge_down) |=> $stable(word_o));

    // R4: any transition in half-rate mode captures the input seen with it
    p_double_edge_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == CAP_DOUBLE && (edge_up || edge_down)) |=> word_o == $past(pin_data, 2));

endmodule

// File: rtl/pser_shift.sv
module pser_shift #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdata_o,
    output logic              rclk_o
);

    localparam int              CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(WORD_W / 2 - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        if (st_q.cnt == LAST) begin
            st_d.shreg = word_i;
        end else begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o = st_q.shreg[WORD_W-1];
    assign rclk_o  = st_q.cnt[CNT_W-1];

    // R2: the wrap edge puts the captured word's MSB on the line
    p_load_on_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LAST) |=> sdata_o == $past(word_i[WORD_W-1]));

    // R5: read clock rises at mid-frame
    p_rclk_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == MID) |=> $rose(rclk_o));

endmodule

// File: rtl/pser_outsel.sv
module pser_outsel (
    input  logic ser_clk,
    input  logic ser_clk_en,
    input  logic ser_bit,
    input  logic rd_clk,
    input  logic lb_on,
    input  logic lb_data_sel,
    output logic ser_clk_o,
    output logic aux_o
);

    always_comb begin
        ser_clk_o = ser_clk & ser_clk_en;
        if (!lb_on) begin
            aux_o = 1'b0;
        end else if (lb_data_sel) begin
            aux_o = ser_bit;
        end else begin
            aux_o = rd_clk;
        end
    end

endmodule

// File: rtl/pser_tx.sv
module pser_tx
    import pser_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              clk_ser,
    input  logic              rst_n,
    input  logic              pclk_in,
    input  logic [WORD_W-1:0] pdata_in,
    input  logic [1:0]        mode_in,
    input  logic              lb_en,
    input  logic              lb_pwr,
    output logic              sdata_out,
    output logic              sclk_out,
    output logic              rclk_out,
    output logic              aux_out
);

    logic [WORD_W-1:0] cap_word;
    cap_mode_e         cap_mode;

    assign cap_mode = cap_mode_e'(mode_in[1]);

    pser_capture #(.WORD_W(WORD_W)) u_cap (
        .clk      (clk_ser),
        .rst_n    (rst_n),
        .pin_clk  (pclk_in),
        .pin_data (pdata_in),
        .cap_mode (cap_mode),
        .word_o   (cap_word)
    );

    pser_shift #(.WORD_W(WORD_W)) u_sh (
        .clk     (clk_ser),
        .rst_n   (rst_n),
        .word_i  (cap_word),
        .sdata_o (sdata_out),
        .rclk_o  (rclk_out)
    );

    pser_outsel u_out (
        .ser_clk     (clk_ser),
        .ser_clk_en  (mode_in[0]),
        .ser_bit     (sdata_out),
        .rd_clk      (rclk_out),
        .lb_on       (lb_pwr),
        .lb_data_sel (lb_en),
        .ser_clk_o   (sclk_out),
        .aux_o       (aux_out)
    );

    // R7: powered-down loopback output stays low
    p_aux_off_r7: assert property (@(posedge clk_ser) disable iff (!rst_n)
        !lb_pwr |-> !aux_out);

    // R8: enabled loopback copies the serial stream
    p_aux_data_r8: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (lb_pwr && lb_en) |-> aux_out == sdata_out);

    // R9: loopback in clock mode follows the read clock
    p_aux_clk_r9: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (lb_pwr && !lb_en) |-> aux_out == rclk_out);

endmodule

// File: tb/tb_pser_tx.sv
module tb_pser_tx;

    logic       clk_ser = 1'b0;
    logic       rst_n   = 1'b0;
    logic       pclk_in = 1'b0;
    logic [3:0] pdata_in = '0;
    logic [1:0] mode_in = '0;
    logic       lb_en = 1'b0;
    logic       lb_pwr = 1'b0;
    logic       sdata_out, sclk_out, rclk_out, aux_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // reference model state
    int m_s1, m_s2, m_dat, m_hold, m_word, m_phase;

    always #2 clk_ser = ~clk_ser;

    pser_tx dut (
        .clk_ser   (clk_ser),
        .rst_n     (rst_n),
        .pclk_in   (pclk_in),
        .pdata_in  (pdata_in),
        .mode_in   (mode_in),
        .lb_en     (lb_en),
        .lb_pwr    (lb_pwr),
        .sdata_out (sdata_out),
        .sclk_out  (sclk_out),
        .rclk_out  (rclk_out),
        .aux_out   (aux_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int word_of(input int idx, input int seed);
        return (idx * seed + idx / 3 + seed) & 15;
    endfunction

    task automatic run_scn(input logic half, input logic sen, input logic lbp,
                           input logic lbe, input int ncyc, input int seed);
        logic e_sd, e_rc, e_aux;
        int   p, idx, take;
        string cap_tag;
        cap_tag = half ? "R4" : "R3";
        @(negedge clk_ser);
        rst_n    = 1'b0;
        pclk_in  = 1'b0;
        pdata_in = 4'hF;
        mode_in  = {half, sen};
        lb_pwr   = lbp;
        lb_en    = lbe;
        @(negedge clk_ser);
        @(negedge clk_ser);
        // R10: reset state
        chk(sdata_out, 1'b0, "R10 sdata in reset");
        chk(rclk_out, 1'b0, "R10 rclk in reset");
        chk(aux_out, 1'b0, "R10 aux in reset");
        rst_n = 1'b1;
        m_s1 = 0; m_s2 = 0; m_dat = 0; m_hold = 0; m_word = 0; m_phase = 0;
        for (int t = 0; t < ncyc; t++) begin
            if (half) begin
                p   = (t / 4) % 2;
                idx = (t + 2) / 4;
            end else begin
                p   = (t / 2) % 2;
                idx = (t + 1) / 4;
            end
            pclk_in  = p[0];
            pdata_in = 4'(word_of(idx, seed));
            // model the coming rising edge
            take = (m_s1 == 1 && m_s2 == 0) || (half && m_s1 == 0 && m_s2 == 1);
            if (m_phase == 3) m_word = m_hold;
            m_phase = (m_phase + 1) % 4;
            if (take != 0) m_hold = m_dat;
            m_s2  = m_s1;
            m_s1  = p;
            m_dat = word_of(idx, seed);
            e_sd  = m_word[3 - m_phase];
            e_rc  = (m_phase >= 2);
            e_aux = !lbp ? 1'b0 : (lbe ? e_sd : e_rc);
            @(posedge clk_ser);
            #1;
            chk(sclk_out, sen, "R6 sclk_out while clock high");
            @(negedge clk_ser);
            chk(sdata_out, e_sd, {"R1 R2 ", cap_tag, " serial bit"});
            chk(rclk_out, e_rc, "R5 read clock");
            if (!lbp)     chk(aux_out, e_aux, "R7 aux powered down");
            else if (lbe) chk(aux_out, e_aux, "R8 aux data copy");
            else          chk(aux_out, e_aux, "R9 aux read clock");
        end
    endtask

    initial begin
        run_scn(1'b0, 1'b1, 1'b1, 1'b1, 96, 5);
        run_scn(1'b0, 1'b0, 1'b1, 1'b0, 96, 11);
        run_scn(1'b1, 1'b0, 1'b1, 1'b1, 96, 7);
        run_scn(1'b1, 1'b1, 1'b1, 1'b0, 96, 13);
        run_scn(1'b0, 1'b1, 1'b0, 1'b1, 64, 3);
        run_scn(1'b1, 1'b0, 1'b0, 1'b0, 64, 9);
        run_scn(1'b0, 1'b1, 1'b1, 1'b1, 64, 15);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule